// File: doc/BRIEF.md
# Paged Flash Card Configuration Registers

This block sits between the host's attribute-memory port and the flash banks of a removable memory card. It holds two small control registers. The option register carries a soft-reset flag and a two-bit page selector. The page selector lets the host reach storage beyond the direct 64MB common-memory window, one 64MB page at a time. The status register carries a single array power-down flag. Host writes commit on the rising edge of a write strobe, and only when the attribute-space select and the card enable are both high.

From the register state and the hardware reset pin, the block drives three things. It drives a reset/power-down line to every flash bank. It drives a one-hot enable for the page that the current common-memory access falls in. It drives an access-inhibit flag that blocks common-memory traffic. The flag is set while the card is in reset, while the array is powered down, and while the selector holds a page number with no memory behind it. The block also merges the per-bank ready/busy lines into a single card-level ready flag.

Top module: `card_cfg_pager`

## Requirements
- R1: After power-on reset (rst_n low) the page selector, soft-reset flag and power-down flag are all 0. Reads of address 4000h and 4002h return 00h, and every bank_pd bit is low.
- R2: A read of address 4000h returns the soft-reset flag in bit 7 and the page selector in bits 1:0, with bits 6:2 reading 0. A write of address 4000h that leaves the card out of reset loads bits 1:0 into the page selector.
- R3: A register write commits at most once per rising edge of wr_strobe, and only if attr_sel and card_en are both high at that edge. Changing wdata while the strobe stays high has no effect, and so does a strobe pulse without both qualifiers.
- R4: Writing 1 to bit 7 of 4000h enters soft reset. The page selector and the power-down flag are cleared, every bank_pd bit goes high, and access_inhibit goes high. While the card is in soft reset, writes to the page bits and to 4002h are ignored.
- R5: Writing 0 to bit 7 of 4000h while the card is in soft reset leaves reset. The page selector and power-down flag are restored to 0 whatever the other data bits are, and bank_pd goes low.
- R6: When the page selector is at or above NUM_PAGES (page 3 with the default of 3 pages), access_inhibit is high and no page_en bit is set.
- R7: During a common-memory request (mem_req=1, attr_sel=0, card_en=1) with access not inhibited, page_en is the one-hot code of the page selector: bit p is set for page p.
- R8: Bit 2 of 4002h is the power-down flag. Writing 1 drives every bank_pd bit high and sets access_inhibit, and writing 0 releases them. The other bits of 4002h are ignored on write and read as 0.
- R9: While hw_reset is high, every bank_pd bit and access_inhibit are high in the same cycle. At the next clock edge the page selector, soft-reset flag and power-down flag are cleared.
- R10: card_ready is high exactly when every bit of bank_ready is high.
- R11: A write to any attribute address other than 4000h or 4002h changes no register. A read of such an address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_reset | input | 1 | Card reset pin, active high |
| attr_sel | input | 1 | Attribute-space select, active high |
| card_en | input | 1 | Card enable, active high |
| wr_strobe | input | 1 | Host write strobe, active high; a write commits on its rising edge |
| rd_en | input | 1 | Host read enable, active high |
| mem_req | input | 1 | Common-memory access request |
| addr | input | ADDR_W | Attribute address |
| wdata | input | DATA_W | Write data |
| bank_ready | input | NUM_BANKS | Per-bank ready (1) / busy (0) |
| rdata | output | DATA_W | Register read data, 0 when no read is active |
| bank_pd | output | NUM_BANKS | Per-bank reset/power-down, active high |
| page_en | output | NUM_PAGES | One-hot enable of the selected page |
| access_inhibit | output | 1 | Common-memory access blocked |
| card_ready | output | 1 | All banks ready |

## Verification
Several properties are checked on every cycle. The power-down fan-out is always uniform across the banks. page_en is never more than one-hot and never set while inhibited. The reset pin powers the banks down at once and empties the page selector on the following edge. Soft reset never coexists with a nonzero page. A strobe without the attribute select never moves the page. The bench scenarios cover the rest. They show the exact read-back encodings, the single commit when wdata changes under a held strobe, and the rule that writes to the page bits and to 4002h are ignored in soft reset. They also show that leaving soft reset discards the data bits, and that an undefined address stays inert.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
    localparam int PAGE_W = 2;

    typedef struct packed {
        logic              srst;
        logic [PAGE_W-1:0] page;
        logic              pd;
        logic              stb;
    } cfg_state_t;
endpackage

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
    import card_cfg_pkg::*;
#(
    parameter int              ADDR_W    = 15,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 15'h4000,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 15'h4002,
    parameter int              SRST_BIT  = 7,
    parameter int              PD_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset,
    input  logic              attr_sel,
    input  logic              card_en,
    input  logic              wr_strobe,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              srst,
    output logic [PAGE_W-1:0] page,
    output logic              pd
);
    cfg_state_t st_d, st_q;
    logic       wr_go;
    logic       hit_opt, hit_stat;

    assign hit_opt  = (addr == OPT_ADDR);
    assign hit_stat = (addr == STAT_ADDR);

    always_comb begin
        st_d     = st_q;
        st_d.stb = wr_strobe;
        wr_go    = wr_strobe && !st_q.stb && attr_sel && card_en;
        if (hw_reset) begin
            st_d.srst = 1'b0;
            st_d.page = '0;
            st_d.pd   = 1'b0;
        end else if (wr_go && hit_opt) begin
            if (wdata[SRST_BIT]) begin
                st_d.srst = 1'b1;
                st_d.page = '0;
                st_d.pd   = 1'b0;
            end else if (st_q.srst) begin
                st_d.srst = 1'b0;
                st_d.page = '0;
                st_d.pd   = 1'b0;
            end else begin
                st_d.page = wdata[PAGE_W-1:0];
            end
        end else if (wr_go && hit_stat && !st_q.srst) begin
            st_d.pd = wdata[PD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en && attr_sel && card_en) begin
            if (hit_opt) begin
                rdata[SRST_BIT]     = st_q.srst;
                rdata[PAGE_W-1:0]   = st_q.page;
            end else if (hit_stat) begin
                rdata[PD_BIT]       = st_q.pd;
            end
        end
    end

    assign srst = st_q.srst;
    assign page = st_q.page;
    assign pd   = st_q.pd;
endmodule

// File: rtl/card_cfg_gate.sv
module card_cfg_gate
    import card_cfg_pkg::*;
#(
    parameter int NUM_PAGES = 3,
    parameter int NUM_BANKS = 6
) (
    input  logic                 hw_reset,
    input  logic                 srst,
    input  logic                 pd,
    input  logic [PAGE_W-1:0]    page,
    input  logic                 mem_req,
    input  logic                 attr_sel,
    input  logic                 card_en,
    output logic [NUM_BANKS-1:0] bank_pd,
    output logic [NUM_PAGES-1:0] page_en,
    output logic                 access_inhibit
);
    logic        pd_any;
    logic        page_bad;
    logic        mem_go;
    logic [31:0] page_ext;

    assign page_ext       = 32'(page);
    assign page_bad       = (page_ext >= 32'(NUM_PAGES));
    assign pd_any         = hw_reset | srst | pd;
    assign access_inhibit = pd_any | page_bad;
    assign mem_go         = mem_req && !attr_sel && card_en && !access_inhibit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pd
        assign bank_pd[b] = pd_any;
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
        assign page_en[p] = mem_go && (page_ext == 32'(p));
    end
endmodule

// File: rtl/card_cfg_ready.sv
module card_cfg_ready #(
    parameter int NUM_BANKS = 6
) (
    input  logic [NUM_BANKS-1:0] bank_ready,
    output logic                 card_ready
);
    logic [NUM_BANKS:0] chain;
    assign chain[0] = 1'b1;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_and
        assign chain[b+1] = chain[b] & bank_ready[b];
    end
    assign card_ready = chain[NUM_BANKS];
endmodule

// File: rtl/card_cfg_pager.sv
module card_cfg_pager
    import card_cfg_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int NUM_PAGES = 3,
    parameter int NUM_BANKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hw_reset,
    input  logic                 attr_sel,
    input  logic                 card_en,
    input  logic                 wr_strobe,
    input  logic                 rd_en,
    input  logic                 mem_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_BANKS-1:0] bank_ready,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_BANKS-1:0] bank_pd,
    output logic [NUM_PAGES-1:0] page_en,
    output logic                 access_inhibit,
    output logic                 card_ready
);
    logic              srst_w;
    logic              pd_w;
    logic [PAGE_W-1:0] page_w;

    card_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_reset  (hw_reset),
        .attr_sel  (attr_sel),
        .card_en   (card_en),
        .wr_strobe (wr_strobe),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .srst      (srst_w),
        .page      (page_w),
        .pd        (pd_w)
    );

    card_cfg_gate #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_BANKS (NUM_BANKS)
    ) u_gate (
        .hw_reset       (hw_reset),
        .srst           (srst_w),
        .pd             (pd_w),
        .page           (page_w),
        .mem_req        (mem_req),
        .attr_sel       (attr_sel),
        .card_en        (card_en),
        .bank_pd        (bank_pd),
        .page_en        (page_en),
        .access_inhibit (access_inhibit)
    );

    card_cfg_ready #(
        .NUM_BANKS (NUM_BANKS)
    ) u_ready (
        .bank_ready (bank_ready),
        .card_ready (card_ready)
    );
endmodule

// File: rtl/card_cfg_pager_chk.sv
module card_cfg_pager_chk
    import card_cfg_pkg::*;
#(
    parameter int NUM_PAGES = 3,
    parameter int NUM_BANKS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hw_reset,
    input logic                 attr_sel,
    input logic                 srst_w,
    input logic [PAGE_W-1:0]    page_w,
    input logic [NUM_BANKS-1:0] bank_pd,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic [NUM_PAGES-1:0] page_en,
    input logic                 access_inhibit,
    input logic                 card_ready
);
    AST_PD_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_pd == '0) || (bank_pd == '1)); // R4
    AST_HWRST_PD: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |-> ((bank_pd == '1) && access_inhibit)); // R9
    AST_HWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |=> (page_w == '0) && !srst_w); // R9
    AST_PAGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_en)); // R7
    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        access_inhibit |-> (page_en == '0)); // R6
    AST_SRST_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        srst_w |-> (page_w == '0) && (bank_pd == '1)); // R4
    AST_NOSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!attr_sel && !hw_reset) |=> $stable(page_w)); // R3
    AST_READY_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        card_ready == ($countones(bank_ready) == NUM_BANKS)); // R10
endmodule

bind card_cfg_pager card_cfg_pager_chk #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_BANKS (NUM_BANKS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_reset       (hw_reset),
    .attr_sel       (attr_sel),
    .srst_w         (srst_w),
    .page_w         (page_w),
    .bank_pd        (bank_pd),
    .bank_ready     (bank_ready),
    .page_en        (page_en),
    .access_inhibit (access_inhibit),
    .card_ready     (card_ready)
);

// File: tb/card_cfg_pager_tb_top.sv
module card_cfg_pager_tb_top;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int NP = 3;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_reset = 1'b0;
    logic          attr_sel = 1'b0;
    logic          card_en = 1'b0;
    logic          wr_strobe = 1'b0;
    logic          rd_en = 1'b0;
    logic          mem_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] bank_ready = '1;
    logic [DW-1:0] rdata;
    logic [NB-1:0] bank_pd;
    logic [NP-1:0] page_en;
    logic          access_inhibit;
    logic          card_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    card_cfg_pager #(.ADDR_W(AW), .DATA_W(DW), .NUM_PAGES(NP), .NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .attr_sel(attr_sel),
        .card_en(card_en), .wr_strobe(wr_strobe), .rd_en(rd_en), .mem_req(mem_req),
        .addr(addr), .wdata(wdata), .bank_ready(bank_ready), .rdata(rdata),
        .bank_pd(bank_pd), .page_en(page_en), .access_inhibit(access_inhibit),
        .card_ready(card_ready)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every active read, mid-cycle
    always @(negedge clk) begin
        if (rd_en) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, 32'(rdata), 32'(it.exp));
            end
        end
    end

    task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
        rd_item_t it;
        @(posedge clk); #1;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        attr_sel = 1'b1; card_en = 1'b1; addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0; attr_sel = 1'b0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic sel, logic ce);
        @(posedge clk); #1;
        attr_sel = sel; card_en = ce; addr = a; wdata = d; wr_strobe = 1'b1;
        @(posedge clk); #1;
        wr_strobe = 1'b0; attr_sel = 1'b0;
    endtask

    task automatic mem_probe(logic [NP-1:0] exp_en, logic exp_inh, string tag);
        @(posedge clk); #1;
        mem_req = 1'b1; attr_sel = 1'b0; card_en = 1'b1;
        @(negedge clk);
        check(tag, 32'(page_en), 32'(exp_en));
        check(tag, 32'(access_inhibit), 32'(exp_inh));
        @(posedge clk); #1;
        mem_req = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 bank_pd after reset", 32'(bank_pd), 32'h0);
        rd(15'h4000, 8'h00, "R1 option reads 0");
        rd(15'h4002, 8'h00, "R1 status reads 0");

        wr(15'h4000, 8'h02, 1, 1);
        rd(15'h4000, 8'h02, "R2 page 2 readback");
        wr(15'h4000, 8'h7D, 1, 1);
        rd(15'h4000, 8'h01, "R2 page 1, bits 6:2 read 0");

        mem_probe(3'b010, 1'b0, "R7 page 1 enable");
        wr(15'h4000, 8'h00, 1, 1);
        mem_probe(3'b001, 1'b0, "R7 page 0 enable");
        wr(15'h4000, 8'h02, 1, 1);
        mem_probe(3'b100, 1'b0, "R7 page 2 enable");

        wr(15'h4000, 8'h03, 1, 1);
        rd(15'h4000, 8'h03, "R6 page 3 readback");
        mem_probe(3'b000, 1'b1, "R6 page 3 inhibits");

        wr(15'h4000, 8'h01, 0, 1);
        rd(15'h4000, 8'h03, "R3 no attr_sel ignored");
        wr(15'h4000, 8'h01, 1, 0);
        rd(15'h4000, 8'h03, "R3 no card_en ignored");
        // strobe held high while data changes: only the first value lands
        @(posedge clk); #1;
        attr_sel = 1'b1; card_en = 1'b1; addr = 15'h4000; wdata = 8'h01; wr_strobe = 1'b1;
        @(posedge clk); #1 wdata = 8'h02;
        @(posedge clk); #1 wdata = 8'h00;
        @(posedge clk); #1 wr_strobe = 1'b0; attr_sel = 1'b0;
        rd(15'h4000, 8'h01, "R3 held strobe commits once");

        wr(15'h4002, 8'hFF, 1, 1);
        rd(15'h4002, 8'h04, "R8 only bit 2 kept");
        @(negedge clk);
        check("R8 bank_pd on power-down", 32'(bank_pd), 32'h3F);
        check("R8 inhibit on power-down", 32'(access_inhibit), 32'h1);
        wr(15'h4002, 8'h00, 1, 1);
        rd(15'h4002, 8'h00, "R8 power-down cleared");
        @(negedge clk);
        check("R8 bank_pd released", 32'(bank_pd), 32'h0);

        wr(15'h4004, 8'hFF, 1, 1);
        rd(15'h4000, 8'h01, "R11 option untouched");
        rd(15'h4002, 8'h00, "R11 status untouched");
        rd(15'h4004, 8'h00, "R11 undefined reads 0");

        wr(15'h4000, 8'h02, 1, 1);
        wr(15'h4002, 8'h04, 1, 1);
        wr(15'h4000, 8'h80, 1, 1);
        rd(15'h4000, 8'h80, "R4 soft reset, page forced 0");
        rd(15'h4002, 8'h00, "R4 power-down cleared by soft reset");
        @(negedge clk);
        check("R4 bank_pd in soft reset", 32'(bank_pd), 32'h3F);
        check("R4 inhibit in soft reset", 32'(access_inhibit), 32'h1);
        wr(15'h4000, 8'h81, 1, 1);
        rd(15'h4000, 8'h80, "R4 page write ignored in reset");
        wr(15'h4002, 8'h04, 1, 1);
        rd(15'h4002, 8'h00, "R4 status write ignored in reset");

        wr(15'h4000, 8'h02, 1, 1);
        rd(15'h4000, 8'h00, "R5 leaving reset restores defaults");
        @(negedge clk);
        check("R5 bank_pd released", 32'(bank_pd), 32'h0);
        wr(15'h4000, 8'h02, 1, 1);
        rd(15'h4000, 8'h02, "R5 page writable again");

        @(posedge clk); #1 hw_reset = 1'b1;
        @(negedge clk);
        check("R9 bank_pd immediate", 32'(bank_pd), 32'h3F);
        check("R9 inhibit immediate", 32'(access_inhibit), 32'h1);
        @(posedge clk); #1 hw_reset = 1'b0;
        rd(15'h4000, 8'h00, "R9 page cleared by pin");

        @(negedge clk);
        check("R10 all ready", 32'(card_ready), 32'h1);
        bank_ready = 6'b111011;
        #1 check("R10 one busy", 32'(card_ready), 32'h0);
        bank_ready = 6'b000000;
        #1 check("R10 all busy", 32'(card_ready), 32'h0);
        bank_ready = 6'b111111;

        repeat (2) @(posedge clk);
        check("scoreboard drained", 32'(sb_q.size()), 32'h0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule